// File: doc/BRIEF.md
# Byte-Chained Subtract and Compare Unit

An 8-bit arithmetic and logic unit with its own status-flag register, built so that subtractions and comparisons of 16-, 24- or 32-bit values done one byte at a time leave correct flags after the most significant byte. The borrow from each byte feeds the next. The zero flag is also carried along the chain: a with-borrow operation can only keep it set, never set it. A single equality branch after the last byte is then correct for the whole multi-byte value.

Each cycle the caller presents two operands and an immediate, an opcode and a valid strobe. On the next clock edge the unit registers the result, a write-enable for the destination register, and the carry, zero, negative, overflow and sign flags. Compare forms update only the flags, so both operands survive. A with-borrow immediate form lets software add a wide constant by subtracting its negation byte by byte.

Top module: `chain_alu8`

## Requirements
- R1: Opcode 0 (subtract) and opcode 9 (subtract immediate, subtrahend taken from `imm_in`) register result = A − B mod 256 with write-enable 1. Carry = 1 exactly when A < B unsigned. Zero depends on this byte's result only.
- R2: Opcode 1 (subtract with borrow) registers A − B − C. C is the carry flag held before the operation, and carry = 1 exactly when A < B + C unsigned. The new zero flag = (result is 0) AND (old zero flag).
- R3: Opcode 2 (subtract with borrow, immediate) behaves as opcode 1 with `imm_in` in place of B, including the chained zero flag.
- R4: Opcode 3 (compare) sets all flags as opcode 0 would. It gives write-enable 0 and leaves the result output unchanged.
- R5: Opcode 4 (compare with borrow) sets all flags as opcode 1 would, chained zero included. It gives write-enable 0 and leaves the result output unchanged.
- R6: Opcode 5 (compare immediate) sets all flags from A − `imm_in` as opcode 9 would, with write-enable 0 and the result output unchanged.
- R7: For every arithmetic opcode: negative = bit 7 of the 8-bit difference, overflow = the two's-complement signed result lies outside −128..127, and sign = negative XOR overflow.
- R8: Opcodes 6, 7 and 8 register A AND B, A OR B and A XOR B with write-enable 1. Zero and negative come from the result, overflow = 0, sign = negative, and carry keeps its old value.
- R9: When `op_valid` is 0, or the opcode is 10 to 15, no flag changes, write-enable is 0 and the result output holds.
- R10: After reset, result = 0, write-enable = 0 and all five flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Perform the presented operation at this edge |
| op_code | input | 4 | Operation select (encodings in the requirements) |
| opnd_a | input | 8 | First operand (minuend) |
| opnd_b | input | 8 | Second operand (subtrahend) for register forms |
| imm_in | input | 8 | Constant operand for immediate forms |
| res_out | output | 8 | Registered result |
| res_we | output | 1 | Registered destination write-enable |
| flag_c | output | 1 | Carry (unsigned borrow) |
| flag_z | output | 1 | Zero, chained through with-borrow forms |
| flag_n | output | 1 | Negative |
| flag_v | output | 1 | Two's-complement overflow |
| flag_s | output | 1 | Sign (negative XOR overflow) |

## Verification
The hardest case to reach is a multi-byte pair whose most significant bytes match but whose lower bytes differ. A per-byte zero flag would wrongly report equality there, and random operands almost never produce it. The stimulus builds 32-bit chains directly: exactly equal values, values differing only in the lowest byte, and chains started by either a subtract or a compare. A behavioural model checks every cycle, so a wrong borrow or zero hand-off is caught at the byte where it first appears. Random operation streams then mix chained and unchained opcodes, invalid cycles and undefined opcodes to exercise flag holding.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int DW = 8;

    typedef enum logic [3:0] {
        OP_SUB  = 4'd0,
        OP_SBC  = 4'd1,
        OP_SBCI = 4'd2,
        OP_CMP  = 4'd3,
        OP_CMPB = 4'd4,
        OP_CMPI = 4'd5,
        OP_AND  = 4'd6,
        OP_OR   = 4'd7,
        OP_XOR  = 4'd8,
        OP_SUBI = 4'd9
    } opcode_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2
    } logic_sel_e;

    typedef struct packed {
        logic c;
        logic z;
        logic n;
        logic v;
        logic s;
    } flags_t;

    typedef struct packed {
        logic       known;
        logic       use_imm;
        logic       use_cin;
        logic       chain_z;
        logic       write;
        logic       is_logic;
        logic_sel_e lsel;
    } ctrl_t;

endpackage

// File: rtl/alu8_decode.sv
module alu8_decode
    import alu8_pkg::*;
(
    input  logic [3:0] op_code,
    output ctrl_t      ctrl
);
    always_comb begin
        ctrl = '{known: 1'b1, use_imm: 1'b0, use_cin: 1'b0, chain_z: 1'b0,
                 write: 1'b0, is_logic: 1'b0, lsel: LG_AND};
        case (op_code)
            OP_SUB:  ctrl.write = 1'b1;
            OP_SUBI: begin
                ctrl.write   = 1'b1;
                ctrl.use_imm = 1'b1;
            end
            OP_SBC: begin
                ctrl.write   = 1'b1;
                ctrl.use_cin = 1'b1;
                ctrl.chain_z = 1'b1;
            end
            OP_SBCI: begin
                ctrl.write   = 1'b1;
                ctrl.use_cin = 1'b1;
                ctrl.chain_z = 1'b1;
                ctrl.use_imm = 1'b1;
            end
            OP_CMP:  ctrl.write = 1'b0;
            OP_CMPB: begin
                ctrl.use_cin = 1'b1;
                ctrl.chain_z = 1'b1;
            end
            OP_CMPI: ctrl.use_imm = 1'b1;
            OP_AND: begin
                ctrl.write    = 1'b1;
                ctrl.is_logic = 1'b1;
                ctrl.lsel     = LG_AND;
            end
            OP_OR: begin
                ctrl.write    = 1'b1;
                ctrl.is_logic = 1'b1;
                ctrl.lsel     = LG_OR;
            end
            OP_XOR: begin
                ctrl.write    = 1'b1;
                ctrl.is_logic = 1'b1;
                ctrl.lsel     = LG_XOR;
            end
            default: ctrl.known = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu8_subtractor.sv
module alu8_subtractor #(
    parameter int W = 8
) (
    input  logic [W-1:0] min_i,
    input  logic [W-1:0] sub_i,
    input  logic         bin_i,
    output logic [W-1:0] diff_o,
    output logic         bout_o,
    output logic         ovf_o
);
    localparam int XW = W + 1;

    logic [XW-1:0] wide;

    always_comb begin
        wide   = {1'b0, min_i} - {1'b0, sub_i} - XW'(bin_i);
        diff_o = wide[W-1:0];
        bout_o = wide[W];
        ovf_o  = (min_i[W-1] != sub_i[W-1]) && (wide[W-1] != min_i[W-1]);
    end
endmodule

// File: rtl/alu8_flag_unit.sv
module alu8_flag_unit
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  flags_t       old_i,
    input  logic         is_logic_i,
    input  logic         chain_z_i,
    input  logic [W-1:0] value_i,
    input  logic         borrow_i,
    input  logic         ovf_i,
    output flags_t       new_o
);
    logic byte_zero;

    always_comb begin
        byte_zero = (value_i == '0);
        new_o.n   = value_i[W-1];
        if (is_logic_i) begin
            new_o.c = old_i.c;
            new_o.v = 1'b0;
            new_o.z = byte_zero;
        end else begin
            new_o.c = borrow_i;
            new_o.v = ovf_i;
            new_o.z = chain_z_i ? (byte_zero & old_i.z) : byte_zero;
        end
        new_o.s = new_o.n ^ new_o.v;
    end
endmodule

// File: rtl/chain_alu8.sv
module chain_alu8
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         op_valid,
    input  logic [3:0]   op_code,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic [W-1:0] imm_in,
    output logic [W-1:0] res_out,
    output logic         res_we,
    output logic         flag_c,
    output logic         flag_z,
    output logic         flag_n,
    output logic         flag_v,
    output logic         flag_s
);
    typedef struct packed {
        logic [W-1:0] res;
        logic         we;
        flags_t       flg;
    } state_t;

    state_t       st_d, st_q;
    ctrl_t        ctrl;
    logic [W-1:0] sub_opnd;
    logic [W-1:0] diff;
    logic         borrow, ovf;
    logic [W-1:0] logic_res;
    logic [W-1:0] alu_res;
    flags_t       flg_new;

    alu8_decode i_dec (
        .op_code (op_code),
        .ctrl    (ctrl)
    );

    assign sub_opnd = ctrl.use_imm ? imm_in : opnd_b;

    alu8_subtractor #(.W(W)) i_sub (
        .min_i  (opnd_a),
        .sub_i  (sub_opnd),
        .bin_i  (ctrl.use_cin & st_q.flg.c),
        .diff_o (diff),
        .bout_o (borrow),
        .ovf_o  (ovf)
    );

    always_comb begin
        case (ctrl.lsel)
            LG_OR:   logic_res = opnd_a | opnd_b;
            LG_XOR:  logic_res = opnd_a ^ opnd_b;
            default: logic_res = opnd_a & opnd_b;
        endcase
        alu_res = ctrl.is_logic ? logic_res : diff;
    end

    alu8_flag_unit #(.W(W)) i_flags (
        .old_i      (st_q.flg),
        .is_logic_i (ctrl.is_logic),
        .chain_z_i  (ctrl.chain_z),
        .value_i    (alu_res),
        .borrow_i   (borrow),
        .ovf_i      (ovf),
        .new_o      (flg_new)
    );

    always_comb begin
        st_d    = st_q;
        st_d.we = 1'b0;
        if (op_valid && ctrl.known) begin
            st_d.flg = flg_new;
            if (ctrl.write) begin
                st_d.res = alu_res;
                st_d.we  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_out = st_q.res;
    assign res_we  = st_q.we;
    assign flag_c  = st_q.flg.c;
    assign flag_z  = st_q.flg.z;
    assign flag_n  = st_q.flg.n;
    assign flag_v  = st_q.flg.v;
    assign flag_s  = st_q.flg.s;

    a_r1_sub_borrow: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd0) |=> (flag_c == ($past(opnd_a) < $past(opnd_b))));

    a_r2_chain_z_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == 4'd1 || op_code == 4'd2 || op_code == 4'd4) && !flag_z)
        |=> !flag_z);

    a_r5_compare_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == 4'd3 || op_code == 4'd4 || op_code == 4'd5))
        |=> (!res_we && $stable(res_out)));

    a_r8_logic_keeps_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == 4'd6 || op_code == 4'd7 || op_code == 4'd8))
        |=> (!flag_v && $stable(flag_c)));

    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid || op_code > 4'd9)
        |=> (!res_we && $stable(res_out) && $stable({flag_c, flag_z, flag_n, flag_v, flag_s})));

endmodule

// File: tb/test_chain_alu8.sv
`timescale 1ns/1ps
module test_chain_alu8;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [3:0] op_code = '0;
    logic [7:0] opnd_a = '0, opnd_b = '0, imm_in = '0;
    logic [7:0] res_out;
    logic       res_we, flag_c, flag_z, flag_n, flag_v, flag_s;

    int tests = 0;
    int fails = 0;

    // reference state
    int m_res = 0;
    int m_we = 0;
    int m_c = 0, m_z = 0, m_n = 0, m_v = 0, m_s = 0;

    always #2 clk = ~clk;

    chain_alu8 i_chain_alu8 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .imm_in(imm_in),
        .res_out(res_out), .res_we(res_we), .flag_c(flag_c), .flag_z(flag_z),
        .flag_n(flag_n), .flag_v(flag_v), .flag_s(flag_s)
    );

    function automatic string tag_of(input bit v, input int op);
        if (!v || op > 9) return "R9";
        case (op)
            0, 9:    return "R1";
            1:       return "R2";
            2:       return "R3";
            3:       return "R4";
            4:       return "R5";
            5:       return "R6";
            default: return "R8";
        endcase
    endfunction

    task automatic compare_all(input string tag);
        int got, exp;
        got = {res_out, res_we, flag_c, flag_z, flag_n, flag_v, flag_s};
        exp = (m_res << 6) | (m_we << 5) | (m_c << 4) | (m_z << 3) | (m_n << 2) | (m_v << 1) | m_s;
        tests++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s res/we/c/z/n/v/s actual=%h_%b expected=%h_%b",
                     tag, got >> 6, got[5:0], exp >> 6, exp[5:0]);
        end
    endtask

    task automatic model(input bit v, input int op, input int a, input int b, input int im);
        int sb, cin, d, r, sa, sbs, sd;
        bit chain, wr;
        m_we = 0;
        if (!v || op > 9) return;
        if (op >= 6 && op <= 8) begin
            r = (op == 6) ? (a & b) : (op == 7) ? (a | b) : (a ^ b);
            m_res = r; m_we = 1;
            m_z = (r == 0); m_n = (r >> 7) & 1; m_v = 0; m_s = m_n;
            return;
        end
        sb    = (op == 2 || op == 5 || op == 9) ? im : b;
        cin   = (op == 1 || op == 2 || op == 4) ? m_c : 0;
        chain = (op == 1 || op == 2 || op == 4);
        wr    = (op == 0 || op == 1 || op == 2 || op == 9);
        d = a - sb - cin;
        r = d & 255;
        sa  = (a  > 127) ? a  - 256 : a;
        sbs = (sb > 127) ? sb - 256 : sb;
        sd  = sa - sbs - cin;
        m_c = (d < 0);
        m_z = (r == 0) && (chain ? (m_z == 1) : 1'b1);
        m_n = (r >> 7) & 1;
        m_v = (sd < -128 || sd > 127);
        m_s = m_n ^ m_v;
        if (wr) begin m_res = r; m_we = 1; end
    endtask

    task automatic step(input bit v, input int op, input int a, input int b, input int im, input string tag);
        op_valid = v; op_code = op[3:0]; opnd_a = a[7:0]; opnd_b = b[7:0]; imm_in = im[7:0];
        @(posedge clk);
        model(v, op, a, b, im);
        @(negedge clk);
        compare_all(tag);
    endtask

    task automatic op1(input int op, input int a, input int b, input int im);
        step(1'b1, op, a, b, im, tag_of(1'b1, op));
    endtask

    task automatic wide_cmp(input int x, input int y, input bit use_cmp);
        op1(use_cmp ? 3 : 0, x & 255, y & 255, 0);
        for (int k = 1; k < 4; k++)
            op1(use_cmp ? 4 : 1, (x >> (8*k)) & 255, (y >> (8*k)) & 255, 0);
        tests++;
        if (flag_z != (x == y)) begin
            fails++;
            $display("FAIL R2/R5 32-bit equality actual=%0d expected=%0d", flag_z, x == y);
        end
    endtask

    initial begin
        repeat (2) @(negedge clk);
        compare_all("R10");
        rst_n = 1'b1;
        @(negedge clk);
        compare_all("R10");

        // R1 plain subtract, borrow and zero of this byte only
        op1(0, 5, 5, 0);
        op1(0, 3, 4, 0);
        op1(9, 10, 0, 10);
        // R7 signed overflow corners
        op1(0, 8'h80, 1, 0);
        op1(0, 8'h7F, 8'hFF, 0);
        op1(0, 0, 8'h80, 0);
        // R2/R5 chained equality: equal, low bytes differ, via subtract and compare
        wide_cmp(32'h12345678, 32'h12345678, 1'b0);
        wide_cmp(32'h12345600, 32'h12345601, 1'b0);
        wide_cmp(32'hAB000001, 32'hAB000000, 1'b1);
        wide_cmp(32'h00000000, 32'h00000000, 1'b1);
        // R3 16-bit add of 0x1234 via subtracting its negation 0xEDCC
        op1(9, 8'h50, 0, 8'hCC);
        op1(2, 8'h10, 0, 8'hED);
        tests++;
        if (res_out != 8'h22) begin
            fails++;
            $display("FAIL R3 high byte actual=%h expected=22", res_out);
        end
        // R6 compare immediate; R4 compare
        op1(5, 8'h40, 0, 8'h40);
        op1(3, 8'h01, 8'h02, 0);
        // R8 logic with carry set beforehand
        op1(0, 0, 1, 0);
        op1(6, 8'hF0, 8'h0F, 0);
        op1(7, 8'h80, 8'h01, 0);
        op1(8, 8'hAA, 8'hAA, 0);
        // R9 invalid and undefined opcodes
        step(1'b0, 0, 1, 2, 3, "R9");
        step(1'b1, 12, 1, 2, 3, "R9");
        step(1'b1, 15, 0, 0, 0, "R9");
        // random mix
        for (int i = 0; i < 600; i++) begin
            int op;
            bit v;
            op = $urandom_range(0, 15);
            v  = ($urandom_range(0, 7) != 0);
            step(v, op, $urandom_range(0, 255), $urandom_range(0, 255),
                 $urandom_range(0, 255), tag_of(v, op));
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule